// File: doc/BRIEF.md
# Dual-Port Indexed Configuration Register File

This block holds a small bank of 8-bit configuration registers that the rest of the chip reads as plain outputs. Software reaches the bank through an I/O strobe interface. It uses a 10-bit address and 8-bit data. Access is indirect: software first writes a register index to an index port, then makes exactly one access to the paired data port.

Two independent index/data pairs share the bank. The normal pair sits at 022h/023h and the system-management pair sits at 026h/027h. Each pair keeps its own saved index and its own "armed" flag. Management code can therefore complete its own indexed access between a normal index write and the normal data access without disturbing the interrupted sequence.

The block also decodes a few fixed system I/O addresses and raises a select strobe for each. The logic behind those ports lives elsewhere.

Top module: `cfg_index_regfile`

## Requirements
- R1: After reset all registers on `cfg_bus` are 00h, both saved indices are 00h and both armed flags are clear, so a data-port read issued before any index write returns FFh.
- R2: A write to 022h stores the data byte as pair A's index and arms pair A. A read of 023h then returns, in the same cycle, the register that index selects. A write of 023h instead updates that register, which shows on `cfg_bus` after the next rising clock edge. Slot k occupies `cfg_bus[8k+7:8k]`: slot 0 is index 01h and slots 1 to 5 are indices 08h to 0Ch.
- R3: Any data-port access (read or write) clears its pair's armed flag. A second access without a fresh index write behaves as unarmed.
- R4: A data-port access while the pair is unarmed returns FFh on a read and leaves every register unchanged on a write.
- R5: Ports 026h (index, write-only) and 027h (data) give the same indexed access through pair B, with pair B's own index and armed flag.
- R6: An access through either pair leaves the other pair's saved index and armed flag unchanged.
- R7: An armed access to an index outside {01h, 08h..0Ch} returns FFh on a read, discards a write, and still clears the armed flag.
- R8: A read of 022h or 026h returns FFh and changes no state.
- R9: Decoding compares all 10 address bits. For example, 122h and 123h hit no port.
- R10: A strobe is high only in a cycle with `io_rd` or `io_wr` asserted and a matching address, at most one at a time. The matches are: `sel_mouse_clr` at 060h, `sel_port_b` at 061h, `sel_sys_ctl` at 092h, and `sel_fpu_clr` at 0F0h or 0F1h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 10 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, FFh when nothing drives it |
| cfg_bus | output | 48 | Register contents, slot k in bits 8k+7:8k |
| sel_mouse_clr | output | 1 | Select for port 060h |
| sel_port_b | output | 1 | Select for port 061h |
| sel_sys_ctl | output | 1 | Select for port 092h |
| sel_fpu_clr | output | 1 | Select for ports 0F0h/0F1h |

## Verification
Read data and select strobes are combinational, so they are due in the same cycle as the strobe. Register updates and flag changes take effect at the next rising edge. Stimulus is driven at the falling edge. Same-cycle results are sampled 2 ns later, well before the following rising edge. Register contents are sampled at the falling edge after the write's rising edge, so every check lands in the cycle its result is due.

// File: rtl/cfgrf_pkg.sv
// Shared constants, types and index mapping for the configuration register file.
// Assumes one lone index plus one contiguous block of indices.
package cfgrf_pkg;
    localparam int NUM_SLOTS  = 6;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 10;
    localparam int SLOT_W     = $clog2(NUM_SLOTS);
    localparam int BLOCK_LEN  = NUM_SLOTS - 1;
    localparam int NUM_PAIRS  = 2;

    localparam logic [7:0] LONE_IDX   = 8'h01;
    localparam logic [7:0] BLOCK_BASE = 8'h08;

    localparam logic [ADDR_W-1:0] PAIR_A_BASE   = 10'h022;
    localparam logic [ADDR_W-1:0] PAIR_B_BASE   = 10'h026;
    localparam logic [ADDR_W-1:0] MOUSE_ADDR    = 10'h060;
    localparam logic [ADDR_W-1:0] PORTB_ADDR    = 10'h061;
    localparam logic [ADDR_W-1:0] SYSCTL_ADDR   = 10'h092;
    localparam logic [ADDR_W-1:0] FPU_ADDR_EVEN = 10'h0F0;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] slot;
    } slot_map_t;

    // Translate a stored index into a register slot and a hit flag.
    function automatic slot_map_t map_index(input logic [7:0] idx);
        slot_map_t r;
        int off;
        r = '0;
        off = int'(idx) - int'(BLOCK_BASE) + 1;
        if (idx == LONE_IDX) begin
            r.hit  = 1'b1;
            r.slot = '0;
        end else if (off >= 1 && off <= BLOCK_LEN) begin
            r.hit  = 1'b1;
            r.slot = SLOT_W'(off);
        end
        return r;
    endfunction
endpackage

// File: rtl/cfgrf_port_pair.sv
// One index/data port pair: saved index and armed flag.
// Assumes io_rd and io_wr are never high together; index port is at BASE,
// data port at BASE+1.
module cfgrf_port_pair
    import cfgrf_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = 10'h022
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic              index_hit_o,
    output logic              data_hit_o,
    output logic [7:0]        idx_o,
    output logic              armed_o
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE + 1'b1;

    logic [7:0] idx_q;
    logic       armed_q;

    // Address match for the two ports of this pair.
    always_comb begin
        index_hit_o = (io_addr == BASE);
        data_hit_o  = (io_addr == DATA_ADDR);
    end

    // Index write arms the pair; any data access disarms it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            armed_q <= 1'b0;
        end else if (io_wr && index_hit_o) begin
            idx_q   <= io_wdata;
            armed_q <= 1'b1;
        end else if ((io_wr || io_rd) && data_hit_o) begin
            armed_q <= 1'b0;
        end
    end

    assign idx_o   = idx_q;
    assign armed_o = armed_q;
endmodule

// File: rtl/cfgrf_regbank.sv
// Bank of configuration registers with one slot-addressed write port.
// Assumes the caller only asserts we_i for a valid slot.
module cfgrf_regbank
    import cfgrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        regs_o [NUM_SLOTS]
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [7:0] val_q;
        // Hold one register; load it when this slot is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val_q <= '0;
            else if (we_i && slot_i == SLOT_W'(s))
                val_q <= wdata_i;
        end
        assign regs_o[s] = val_q;
    end
endmodule

// File: rtl/cfgrf_io_decode.sv
// Fixed system-port select strobes, qualified by an active I/O cycle.
// Assumes a full 10-bit address compare.
module cfgrf_io_decode
    import cfgrf_pkg::*;
(
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              sel_mouse_clr,
    output logic              sel_port_b,
    output logic              sel_sys_ctl,
    output logic              sel_fpu_clr
);
    logic cyc;

    // Raise the strobe matching the current address during an access.
    always_comb begin
        cyc           = io_wr || io_rd;
        sel_mouse_clr = cyc && (io_addr == MOUSE_ADDR);
        sel_port_b    = cyc && (io_addr == PORTB_ADDR);
        sel_sys_ctl   = cyc && (io_addr == SYSCTL_ADDR);
        sel_fpu_clr   = cyc && (io_addr[ADDR_W-1:1] == FPU_ADDR_EVEN[ADDR_W-1:1]);
    end
endmodule

// File: rtl/cfg_index_regfile.sv
// Top: two indexed port pairs sharing one configuration register bank,
// plus fixed system-port select strobes.
// Assumes single-cycle strobes with io_rd and io_wr mutually exclusive.
module cfg_index_regfile
    import cfgrf_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [9:0]                  io_addr,
    input  logic                        io_wr,
    input  logic                        io_rd,
    input  logic [7:0]                  io_wdata,
    output logic [7:0]                  io_rdata,
    output logic [NUM_SLOTS*DATA_W-1:0] cfg_bus,
    output logic                        sel_mouse_clr,
    output logic                        sel_port_b,
    output logic                        sel_sys_ctl,
    output logic                        sel_fpu_clr
);
    localparam logic [ADDR_W-1:0] PAIR_BASE [NUM_PAIRS] = '{PAIR_A_BASE, PAIR_B_BASE};

    logic [NUM_PAIRS-1:0] index_hit;
    logic [NUM_PAIRS-1:0] data_hit;
    logic [NUM_PAIRS-1:0] armed_vec;
    logic [7:0]           idx_vec [NUM_PAIRS];
    logic [7:0]           regs [NUM_SLOTS];

    logic       any_data;
    logic       sel_armed;
    logic [7:0] sel_idx;
    slot_map_t  map;
    logic       reg_we;

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        cfgrf_port_pair #(.BASE(PAIR_BASE[g])) u_pair (
            .clk         (clk),
            .rst_n       (rst_n),
            .io_addr     (io_addr),
            .io_wr       (io_wr),
            .io_rd       (io_rd),
            .io_wdata    (io_wdata),
            .index_hit_o (index_hit[g]),
            .data_hit_o  (data_hit[g]),
            .idx_o       (idx_vec[g]),
            .armed_o     (armed_vec[g])
        );
    end

    // Pick the pair whose data port is addressed and map its index.
    always_comb begin
        any_data  = |data_hit;
        sel_idx   = data_hit[1] ? idx_vec[1]   : idx_vec[0];
        sel_armed = data_hit[1] ? armed_vec[1] : armed_vec[0];
        map       = map_index(sel_idx);
        reg_we    = io_wr && any_data && sel_armed && map.hit;
    end

    cfgrf_regbank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .slot_i  (map.slot),
        .wdata_i (io_wdata),
        .regs_o  (regs)
    );

    // Read data: selected register on an armed valid read, else FFh.
    always_comb begin
        io_rdata = 8'hFF;
        if (io_rd && any_data && sel_armed && map.hit)
            io_rdata = regs[map.slot];
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_flat
        assign cfg_bus[s*DATA_W +: DATA_W] = regs[s];
    end

    cfgrf_io_decode u_dec (
        .io_addr       (io_addr),
        .io_wr         (io_wr),
        .io_rd         (io_rd),
        .sel_mouse_clr (sel_mouse_clr),
        .sel_port_b    (sel_port_b),
        .sel_sys_ctl   (sel_sys_ctl),
        .sel_fpu_clr   (sel_fpu_clr)
    );

    logic unused_ok;
    assign unused_ok = |index_hit;
endmodule

// File: rtl/cfgrf_checker.sv
// Protocol checker for cfg_index_regfile; attached by bind below.
// Assumes the same clock and reset as the block.
module cfgrf_checker
    import cfgrf_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic [9:0]                  io_addr,
    input logic                        io_wr,
    input logic                        io_rd,
    input logic [7:0]                  io_rdata,
    input logic [NUM_SLOTS*DATA_W-1:0] cfg_bus,
    input logic [NUM_PAIRS-1:0]        armed_vec,
    input logic [3:0]                  strobes
);
    assert_arm_on_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && io_addr == 10'h022 |=> armed_vec[0]);

    assert_disarm_after_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) && io_addr == 10'h023 |=> !armed_vec[0]);

    assert_unarmed_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && io_addr == 10'h023 && !armed_vec[0] |-> io_rdata == 8'hFF);

    assert_unarmed_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && io_addr == 10'h023 && !armed_vec[0] |=> $stable(cfg_bus));

    assert_pair_b_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr && io_addr == 10'h026 |=> armed_vec[1]);

    assert_isolation_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) && (io_addr == 10'h026 || io_addr == 10'h027) |=> $stable(armed_vec[0]));

    assert_index_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && (io_addr == 10'h022 || io_addr == 10'h026) |-> io_rdata == 8'hFF);

    assert_strobe_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes));

    assert_strobe_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd || io_wr) |-> strobes == 4'b0);
endmodule

bind cfg_index_regfile cfgrf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_rdata  (io_rdata),
    .cfg_bus   (cfg_bus),
    .armed_vec (armed_vec),
    .strobes   ({sel_mouse_clr, sel_port_b, sel_sys_ctl, sel_fpu_clr})
);

// File: tb/cfg_index_regfile_test.sv
module cfg_index_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [47:0] cfg_bus;
    logic        sel_mouse_clr, sel_port_b, sel_sys_ctl, sel_fpu_clr;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_regs [6];

    always #5 clk = ~clk;

    cfg_index_regfile uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_bus(cfg_bus),
        .sel_mouse_clr(sel_mouse_clr), .sel_port_b(sel_port_b),
        .sel_sys_ctl(sel_sys_ctl), .sel_fpu_clr(sel_fpu_clr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Slot of an implemented index: 01h -> 0, 08h..0Ch -> 1..5.
    function automatic int slot_of(input logic [7:0] idx);
        if (idx == 8'h01) return 0;
        if (idx >= 8'h08 && idx <= 8'h0C) return int'(idx) - 7;
        return -1;
    endfunction

    function automatic logic [47:0] exp_bus();
        logic [47:0] b;
        for (int s = 0; s < 6; s++) b[s*8 +: 8] = exp_regs[s];
        return b;
    endfunction

    task automatic io_write(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #2 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 cfg_bus zero", cfg_bus, 48'h0);
        io_read(10'h023, d);
        check("R1 unarmed read after reset", d, 8'hFF);
        io_read(10'h027, d);
        check("R1 pair B read after reset", d, 8'hFF);
    endtask

    task automatic t_basic();
        logic [7:0] d;
        io_write(10'h022, 8'h09); io_write(10'h023, 8'h5A);
        exp_regs[slot_of(8'h09)] = 8'h5A;
        check("R2 cfg_bus after write", cfg_bus, exp_bus());
        io_write(10'h022, 8'h01); io_write(10'h023, 8'hC3);
        exp_regs[0] = 8'hC3;
        check("R2 slot0 write", cfg_bus, exp_bus());
        io_write(10'h022, 8'h09); io_read(10'h023, d);
        check("R2 read back 09h", d, 8'h5A);
        io_write(10'h022, 8'h0C); io_write(10'h023, 8'h77);
        exp_regs[5] = 8'h77;
        io_write(10'h022, 8'h0C); io_read(10'h023, d);
        check("R2 read back 0Ch", d, 8'h77);
    endtask

    task automatic t_consume();
        logic [7:0] d;
        io_write(10'h022, 8'h01); io_read(10'h023, d);
        check("R3 first read", d, 8'hC3);
        io_read(10'h023, d);
        check("R3 second read unarmed", d, 8'hFF);
        io_write(10'h022, 8'h08); io_write(10'h023, 8'h11);
        exp_regs[1] = 8'h11;
        io_write(10'h023, 8'h22);
        check("R3 second write ignored", cfg_bus, exp_bus());
    endtask

    task automatic t_unarmed();
        logic [7:0] d;
        io_write(10'h023, 8'hEE);
        check("R4 unarmed write ignored", cfg_bus, exp_bus());
        io_read(10'h023, d);
        check("R4 unarmed read FF", d, 8'hFF);
    endtask

    task automatic t_pair_b();
        logic [7:0] d;
        io_write(10'h026, 8'h0A); io_write(10'h027, 8'h3C);
        exp_regs[3] = 8'h3C;
        check("R5 pair B write", cfg_bus, exp_bus());
        io_write(10'h026, 8'h0A); io_read(10'h027, d);
        check("R5 pair B read", d, 8'h3C);
        io_read(10'h027, d);
        check("R5 pair B consumed", d, 8'hFF);
    endtask

    task automatic t_isolation();
        logic [7:0] d;
        io_write(10'h022, 8'h09);
        io_write(10'h026, 8'h0B); io_write(10'h027, 8'h99);
        exp_regs[4] = 8'h99;
        io_read(10'h026, d);
        io_read(10'h023, d);
        check("R6 pair A survives pair B access", d, 8'h5A);
        io_write(10'h026, 8'h0B);
        io_write(10'h022, 8'h01); io_read(10'h023, d);
        check("R6 pair A read", d, 8'hC3);
        io_read(10'h027, d);
        check("R6 pair B survives pair A access", d, 8'h99);
    endtask

    task automatic t_unimpl();
        logic [7:0] d;
        io_write(10'h022, 8'h0D); io_read(10'h023, d);
        check("R7 read unimplemented", d, 8'hFF);
        io_write(10'h022, 8'h05); io_write(10'h023, 8'hAB);
        check("R7 write discarded", cfg_bus, exp_bus());
        io_write(10'h022, 8'h00); io_write(10'h023, 8'hAB);
        check("R7 index 00 discarded", cfg_bus, exp_bus());
        io_write(10'h022, 8'h0F); io_read(10'h023, d); io_read(10'h023, d);
        check("R7 flag cleared", d, 8'hFF);
    endtask

    task automatic t_index_read();
        logic [7:0] d;
        io_write(10'h022, 8'h08);
        io_read(10'h022, d);
        check("R8 index A read FF", d, 8'hFF);
        io_write(10'h026, 8'h0A);
        io_read(10'h026, d);
        check("R8 index B read FF", d, 8'hFF);
        io_read(10'h023, d);
        check("R8 pair A still armed", d, 8'h11);
        io_read(10'h027, d);
        check("R8 pair B still armed", d, 8'h3C);
    endtask

    task automatic t_full_decode();
        logic [7:0] d;
        io_write(10'h122, 8'h08); io_write(10'h123, 8'hF0);
        check("R9 aliased write no effect", cfg_bus, exp_bus());
        io_read(10'h023, d);
        check("R9 aliased index did not arm", d, 8'hFF);
    endtask

    task automatic t_strobes();
        logic [9:0] addrs [6] = '{10'h060, 10'h061, 10'h092, 10'h0F0, 10'h0F1, 10'h160};
        logic [3:0] exps  [6] = '{4'b1000, 4'b0100, 4'b0010, 4'b0001, 4'b0001, 4'b0000};
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            io_addr = addrs[i]; io_rd = (i % 2 == 0); io_wr = (i % 2 == 1);
            #2 check("R10 strobe on access", {sel_mouse_clr, sel_port_b, sel_sys_ctl, sel_fpu_clr}, exps[i]);
            @(negedge clk);
            io_rd = 1'b0; io_wr = 1'b0;
            #2 check("R10 strobe idle", {sel_mouse_clr, sel_port_b, sel_sys_ctl, sel_fpu_clr}, 4'b0);
        end
    endtask

    initial begin
        #2000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < 6; s++) exp_regs[s] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_consume();
        t_unarmed();
        t_pair_b();
        t_isolation();
        t_unimpl();
        t_index_read();
        t_full_decode();
        t_strobes();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule